// File: doc/BRIEF.md
# Fetch-Stage Branch Predictor

This unit sits in an instruction fetch pipeline that is decoupled from execution by an instruction FIFO. Each cycle it may take one pre-decoded branch from fetch: its class, its addressing mode, its address, its operand (a displacement or an absolute address) and its length. One cycle later it reports whether fetch should be steered to a new address. Unconditional branches, and jumps and calls in PC-relative or absolute form, get their targets computed at once. Returns are predicted from a return-address stack. Conditional branches are predicted by a table of 2-bit counters and a tagged target cache.

Each prediction comes with an opaque record (`p_tag`) that travels down the FIFO with the instruction. When the execute stage resolves the branch, it returns that record together with the real outcome. One cycle later the unit reports the cycle cost of the branch. On a misprediction it also raises a flush with the corrected fetch address, and it rolls the return stack back to the state recorded for that branch. Resolution updates the counters and, for a taken branch, places the target in the cache.

Class codes on `f_class`: 0 none, 1 unconditional branch, 2 jump, 3 call, 4 return, 5 conditional branch. Mode codes on `f_mode`: 0 to 4 are register-based forms, 5 is PC-relative with displacement, 6 is PC-relative indexed, 7 is absolute. A PC-relative target is `f_pc + f_opnd` and an absolute target is `f_opnd`. Class 0 is ignored.

Top module: `fetch_branch_predictor`

## Requirements
- R1: One cycle after a fetch of class 1, or of class 2 or 3 with mode 5 or 7, `p_valid` and `p_redir` are high and `p_addr` is the PC-relative or absolute target.
- R2: A jump or call in any other mode gives `p_redir` low. Its resolution reports cost 5, a flush, and `r_addr` equal to `x_next`.
- R3: An early-redirected branch resolves with no flush and a cost of 3, 2 or 1 when `fifo_level` at fetch was 0, 1 or at least 2.
- R4: A call pushes `f_pc + f_len` onto the return stack. A return pops the stack and redirects to the popped address.
- R5: A predicted return costs 2 with no flush when `x_next` equals the predicted address. Otherwise it costs 9 and flushes to `x_next`.
- R6: A return fetched with an empty stack gives `p_redir` low and resolves with cost 8 and a flush to `x_next`.
- R7: The stack holds RAS_DEPTH entries. A push onto a full stack overwrites the oldest entry, so after RAS_DEPTH+1 calls only the newest RAS_DEPTH returns are predicted.
- R8: The counters are 2-bit, indexed by `pc[IDXW:1]`, and reset to 1. A counter value of 2 or more predicts taken. A correctly predicted not-taken branch costs 1.
- R9: A taken resolution writes the target into the cache at that index, tagged with the other PC bits. A later fetch that hits and is predicted taken redirects to the cached target, and a correct taken outcome costs 0.
- R10: A conditional branch predicted taken by its counter but missing in the cache redirects to `f_pc + f_opnd`, and a correct taken outcome costs 1.
- R11: A conditional branch whose direction was mispredicted costs 8, flushes to `x_next`, and still trains its counter.
- R12: A flushing resolution restores the return stack to the state recorded just after that branch's own push or pop. A fetch presented in the same cycle is dropped (`p_valid` low next cycle).
- R13: After reset, `p_valid` and `r_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| f_valid | input | 1 | Fetch presents a branch |
| f_pc | input | AW | Address of the fetched branch |
| f_class | input | 3 | Branch class code |
| f_mode | input | 3 | Addressing mode code |
| f_len | input | 4 | Instruction length in bytes |
| f_opnd | input | AW | Displacement or absolute target |
| fifo_level | input | LW | Entries buffered toward execute |
| p_valid | output | 1 | Prediction result valid |
| p_redir | output | 1 | Steer fetch to `p_addr` |
| p_addr | output | AW | Predicted fetch address |
| p_tag | output | TAGW | Prediction record for the FIFO |
| x_valid | input | 1 | Execute resolves a branch |
| x_pc | input | AW | Address of the resolved branch |
| x_taken | input | 1 | Conditional outcome taken |
| x_next | input | AW | True next address |
| x_tag | input | TAGW | Record returned with the branch |
| r_valid | output | 1 | Resolution result valid |
| r_cost | output | 4 | Cycle cost of the branch |
| r_flush | output | 1 | Flush FIFO and refetch |
| r_addr | output | AW | Corrected fetch address |

## Verification
A stack pointer or count that is off shows up at the next return: `p_addr` one cycle after that fetch points to the wrong return address, or `p_redir` is low when it should be high. A counter or cache entry in the wrong state shows up at the next fetch of that index, in the `p_redir` and `p_addr` values, and one cycle after its resolution as a wrong `r_cost`. A broken rollback stays hidden until the next return is fetched after the flush, so the bench follows each rollback with that return.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef enum logic [2:0] {
    BC_NONE = 3'd0,
    BC_BRA  = 3'd1,
    BC_JMP  = 3'd2,
    BC_CALL = 3'd3,
    BC_RET  = 3'd4,
    BC_BCC  = 3'd5
  } bclass_e;

  typedef enum logic [2:0] {
    AM_IND  = 3'd0,
    AM_PINC = 3'd1,
    AM_PDEC = 3'd2,
    AM_DAN  = 3'd3,
    AM_XAN  = 3'd4,
    AM_DPC  = 3'd5,
    AM_XPC  = 3'd6,
    AM_ABS  = 3'd7
  } amode_e;

  localparam logic [3:0] COST_ACC_SLOW = 4'd3;
  localparam logic [3:0] COST_ACC_MID  = 4'd2;
  localparam logic [3:0] COST_ACC_FAST = 4'd1;
  localparam logic [3:0] COST_FIXED    = 4'd5;
  localparam logic [3:0] COST_RET_OK   = 4'd2;
  localparam logic [3:0] COST_RET_BAD  = 4'd9;
  localparam logic [3:0] COST_RET_NONE = 4'd8;
  localparam logic [3:0] COST_BC_HIT   = 4'd0;
  localparam logic [3:0] COST_BC_TBL   = 4'd1;
  localparam logic [3:0] COST_BC_MISS  = 4'd8;

  function automatic int tag_width(int aw, int depth, int lw);
    return 7 + aw + $clog2(depth) + $clog2(depth + 1) + lw;
  endfunction

endpackage

// File: rtl/bp_ret_stack.sv
module bp_ret_stack #(
  parameter  int DEPTH = 4,
  parameter  int AW    = 32,
  localparam int SPW   = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push,
  input  logic [AW-1:0]  push_addr,
  input  logic           pop,
  input  logic           restore,
  input  logic [SPW-1:0] restore_sp,
  input  logic [CW-1:0]  restore_cnt,
  output logic           top_vld,
  output logic [AW-1:0]  top_addr,
  output logic [SPW-1:0] sp_nxt,
  output logic [CW-1:0]  cnt_nxt
);

  localparam logic [SPW-1:0] SP_ONE  = SPW'(1);
  localparam logic [CW-1:0]  CNT_ONE = CW'(1);
  localparam logic [CW-1:0]  CNT_MAX = CW'(DEPTH);

  logic [AW-1:0]  stk_q [DEPTH];
  logic [SPW-1:0] sp_q;
  logic [CW-1:0]  cnt_q;
  logic           wr_en;
  logic [SPW-1:0] top_idx;

  assign top_idx  = sp_q - SP_ONE;
  assign top_vld  = (cnt_q != '0);
  assign top_addr = stk_q[top_idx];

  always_comb begin
    sp_nxt  = sp_q;
    cnt_nxt = cnt_q;
    wr_en   = 1'b0;
    if (restore) begin
      sp_nxt  = restore_sp;
      cnt_nxt = restore_cnt;
    end else if (push) begin
      wr_en   = 1'b1;
      sp_nxt  = sp_q + SP_ONE;
      cnt_nxt = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_ONE;
    end else if (pop && top_vld) begin
      sp_nxt  = top_idx;
      cnt_nxt = cnt_q - CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q  <= '0;
      cnt_q <= '0;
    end else begin
      sp_q  <= sp_nxt;
      cnt_q <= cnt_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) stk_q[sp_q] <= push_addr;
  end

  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);

  a_r4_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !restore && cnt_q < CNT_MAX) |=> (cnt_q == $past(cnt_q) + CNT_ONE));

endmodule

// File: rtl/bp_dir_pred.sv
module bp_dir_pred #(
  parameter  int AW   = 32,
  parameter  int IDXW = 4,
  localparam int N    = 1 << IDXW,
  localparam int TGW  = AW - IDXW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] lk_pc,
  output logic          lk_taken,
  output logic          lk_hit,
  output logic [AW-1:0] lk_tgt,
  input  logic          up_en,
  input  logic [AW-1:0] up_pc,
  input  logic          up_taken,
  input  logic [AW-1:0] up_tgt
);

  logic [1:0]      ctr_q  [N];
  logic            vld_q  [N];
  logic [TGW-1:0]  key_q  [N];
  logic [AW-1:0]   tgt_q  [N];

  logic [IDXW-1:0] lk_idx, up_idx;
  logic [TGW-1:0]  lk_key, up_key;
  logic [1:0]      ctr_cur, ctr_upd;

  assign lk_idx = lk_pc[IDXW:1];
  assign lk_key = {lk_pc[AW-1:IDXW+1], lk_pc[0]};
  assign up_idx = up_pc[IDXW:1];
  assign up_key = {up_pc[AW-1:IDXW+1], up_pc[0]};

  assign lk_taken = ctr_q[lk_idx][1];
  assign lk_hit   = vld_q[lk_idx] && (key_q[lk_idx] == lk_key);
  assign lk_tgt   = tgt_q[lk_idx];

  always_comb begin
    ctr_cur = ctr_q[up_idx];
    if (up_taken) ctr_upd = (ctr_cur == 2'b11) ? 2'b11 : ctr_cur + 2'b01;
    else          ctr_upd = (ctr_cur == 2'b00) ? 2'b00 : ctr_cur - 2'b01;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        ctr_q[i] <= 2'b01;
        vld_q[i] <= 1'b0;
      end
    end else if (up_en) begin
      ctr_q[up_idx] <= ctr_upd;
      if (up_taken) vld_q[up_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (up_en && up_taken) begin
      key_q[up_idx] <= up_key;
      tgt_q[up_idx] <= up_tgt;
    end
  end

  a_r9_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    (up_en && up_taken) |=> (vld_q[$past(up_idx)] && key_q[$past(up_idx)] == $past(up_key)));

  a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (up_en && up_taken && ctr_q[up_idx] == 2'b11) |=> (ctr_q[$past(up_idx)] == 2'b11));

endmodule

// File: rtl/bp_resolve.sv
module bp_resolve
  import bp_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 3
) (
  input  logic [2:0]    cls,
  input  logic          accel,
  input  logic          hit,
  input  logic          ptaken,
  input  logic          rpred,
  input  logic [AW-1:0] ptgt,
  input  logic [LW-1:0] lvl,
  input  logic          x_taken,
  input  logic [AW-1:0] x_next,
  output logic [3:0]    cost,
  output logic          flush
);

  always_comb begin
    cost  = '0;
    flush = 1'b0;
    unique case (bclass_e'(cls))
      BC_BRA, BC_JMP, BC_CALL: begin
        if (accel) begin
          if (lvl == '0)               cost = COST_ACC_SLOW;
          else if (lvl == LW'(1))      cost = COST_ACC_MID;
          else                         cost = COST_ACC_FAST;
        end else begin
          cost  = COST_FIXED;
          flush = 1'b1;
        end
      end
      BC_RET: begin
        if (!rpred) begin
          cost  = COST_RET_NONE;
          flush = 1'b1;
        end else if (ptgt == x_next) begin
          cost  = COST_RET_OK;
        end else begin
          cost  = COST_RET_BAD;
          flush = 1'b1;
        end
      end
      BC_BCC: begin
        if (ptaken != x_taken) begin
          cost  = COST_BC_MISS;
          flush = 1'b1;
        end else if (x_taken && hit) begin
          cost  = COST_BC_HIT;
        end else begin
          cost  = COST_BC_TBL;
        end
      end
      default: begin
        cost  = '0;
        flush = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/fetch_branch_predictor.sv
module fetch_branch_predictor
  import bp_pkg::*;
#(
  parameter  int AW        = 32,
  parameter  int RAS_DEPTH = 4,
  parameter  int IDXW      = 4,
  parameter  int LW        = 3,
  localparam int TAGW      = tag_width(AW, RAS_DEPTH, LW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            f_valid,
  input  logic [AW-1:0]   f_pc,
  input  logic [2:0]      f_class,
  input  logic [2:0]      f_mode,
  input  logic [3:0]      f_len,
  input  logic [AW-1:0]   f_opnd,
  input  logic [LW-1:0]   fifo_level,
  output logic            p_valid,
  output logic            p_redir,
  output logic [AW-1:0]   p_addr,
  output logic [TAGW-1:0] p_tag,
  input  logic            x_valid,
  input  logic [AW-1:0]   x_pc,
  input  logic            x_taken,
  input  logic [AW-1:0]   x_next,
  input  logic [TAGW-1:0] x_tag,
  output logic            r_valid,
  output logic [3:0]      r_cost,
  output logic            r_flush,
  output logic [AW-1:0]   r_addr
);

  localparam int SPW = $clog2(RAS_DEPTH);
  localparam int CW  = $clog2(RAS_DEPTH + 1);

  typedef struct packed {
    logic [2:0]     cls;
    logic           accel;
    logic           hit;
    logic           ptaken;
    logic           rpred;
    logic [AW-1:0]  ptgt;
    logic [SPW-1:0] sp;
    logic [CW-1:0]  cnt;
    logic [LW-1:0]  lvl;
  } rec_t;

  bclass_e        fcls;
  amode_e         fmode;
  rec_t           f_rec, x_rec;
  logic           fv, eligible, redir_d;
  logic [AW-1:0]  rel_tgt, acc_tgt, redir_addr_d;
  logic           ras_push, ras_pop, ras_top_vld;
  logic [AW-1:0]  ras_top;
  logic [SPW-1:0] ras_sp_nxt;
  logic [CW-1:0]  ras_cnt_nxt;
  logic           dp_taken, dp_hit;
  logic [AW-1:0]  dp_tgt;
  logic [3:0]     res_cost;
  logic           res_flush, flush_now, dp_upd;

  logic            p_valid_q, p_redir_q, r_valid_q, r_flush_q;
  logic [AW-1:0]   p_addr_q, r_addr_q;
  logic [TAGW-1:0] p_tag_q;
  logic [3:0]      r_cost_q;

  assign fcls  = bclass_e'(f_class);
  assign fmode = amode_e'(f_mode);
  assign x_rec = rec_t'(x_tag);

  // Resolution path
  bp_resolve #(.AW(AW), .LW(LW)) u_res (
    .cls(x_rec.cls), .accel(x_rec.accel), .hit(x_rec.hit), .ptaken(x_rec.ptaken),
    .rpred(x_rec.rpred), .ptgt(x_rec.ptgt), .lvl(x_rec.lvl),
    .x_taken(x_taken), .x_next(x_next), .cost(res_cost), .flush(res_flush)
  );

  assign flush_now = x_valid && res_flush;
  assign dp_upd    = x_valid && (bclass_e'(x_rec.cls) == BC_BCC);

  // Fetch path; a fetch in a flushing cycle is wrong-path and is dropped
  assign fv       = f_valid && !flush_now && (fcls != BC_NONE);
  assign eligible = (fcls == BC_BRA) ||
                    (((fcls == BC_JMP) || (fcls == BC_CALL)) &&
                     ((fmode == AM_DPC) || (fmode == AM_ABS)));
  assign rel_tgt  = f_pc + f_opnd;
  assign acc_tgt  = ((fcls != BC_BRA) && (fmode == AM_ABS)) ? f_opnd : rel_tgt;
  assign ras_push = fv && (fcls == BC_CALL);
  assign ras_pop  = fv && (fcls == BC_RET);

  bp_ret_stack #(.DEPTH(RAS_DEPTH), .AW(AW)) u_ras (
    .clk(clk), .rst_n(rst_n),
    .push(ras_push), .push_addr(f_pc + AW'(f_len)), .pop(ras_pop),
    .restore(flush_now), .restore_sp(x_rec.sp), .restore_cnt(x_rec.cnt),
    .top_vld(ras_top_vld), .top_addr(ras_top),
    .sp_nxt(ras_sp_nxt), .cnt_nxt(ras_cnt_nxt)
  );

  bp_dir_pred #(.AW(AW), .IDXW(IDXW)) u_dir (
    .clk(clk), .rst_n(rst_n),
    .lk_pc(f_pc), .lk_taken(dp_taken), .lk_hit(dp_hit), .lk_tgt(dp_tgt),
    .up_en(dp_upd), .up_pc(x_pc), .up_taken(x_taken), .up_tgt(x_next)
  );

  always_comb begin
    redir_d      = 1'b0;
    redir_addr_d = acc_tgt;
    f_rec        = '0;
    f_rec.cls    = f_class;
    f_rec.sp     = ras_sp_nxt;
    f_rec.cnt    = ras_cnt_nxt;
    f_rec.lvl    = fifo_level;
    if (eligible) begin
      redir_d     = 1'b1;
      f_rec.accel = 1'b1;
      f_rec.ptgt  = acc_tgt;
    end else if (fcls == BC_RET) begin
      redir_d      = ras_top_vld;
      redir_addr_d = ras_top;
      f_rec.rpred  = ras_top_vld;
      f_rec.ptgt   = ras_top;
    end else if (fcls == BC_BCC) begin
      redir_d      = dp_taken;
      redir_addr_d = dp_hit ? dp_tgt : rel_tgt;
      f_rec.ptaken = dp_taken;
      f_rec.hit    = dp_hit && dp_taken;
      f_rec.ptgt   = redir_addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_valid_q <= 1'b0;
      p_redir_q <= 1'b0;
      r_valid_q <= 1'b0;
      r_flush_q <= 1'b0;
    end else begin
      p_valid_q <= fv;
      p_redir_q <= fv && redir_d;
      r_valid_q <= x_valid;
      r_flush_q <= flush_now;
    end
  end

  always_ff @(posedge clk) begin
    if (fv) begin
      p_addr_q <= redir_addr_d;
      p_tag_q  <= f_rec;
    end
    if (x_valid) begin
      r_cost_q <= res_cost;
      r_addr_q <= x_next;
    end
  end

  assign p_valid = p_valid_q;
  assign p_redir = p_redir_q;
  assign p_addr  = p_addr_q;
  assign p_tag   = p_tag_q;
  assign r_valid = r_valid_q;
  assign r_cost  = r_cost_q;
  assign r_flush = r_flush_q;
  assign r_addr  = r_addr_q;

  a_r12_flush_drops_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    r_flush |-> !p_valid);

  a_r2_flush_cost: assert property (@(posedge clk) disable iff (!rst_n)
    r_flush |-> (r_cost >= 4'd5));

endmodule

// File: tb/sim_fetch_branch_predictor.sv
module sim_fetch_branch_predictor;
  import bp_pkg::*;

  localparam int AW   = 32;
  localparam int DEP  = 4;
  localparam int LW   = 3;
  localparam int TAGW = tag_width(AW, DEP, LW);

  logic clk = 1'b0;
  logic rst_n;
  logic f_valid, x_valid, x_taken;
  logic [AW-1:0] f_pc, f_opnd, x_pc, x_next;
  logic [2:0] f_class, f_mode;
  logic [3:0] f_len;
  logic [LW-1:0] fifo_level;
  logic p_valid, p_redir, r_valid, r_flush;
  logic [AW-1:0] p_addr, r_addr;
  logic [TAGW-1:0] p_tag, x_tag;
  logic [3:0] r_cost;

  always #2 clk = ~clk;

  fetch_branch_predictor #(.AW(AW), .RAS_DEPTH(DEP), .IDXW(4), .LW(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .f_valid(f_valid), .f_pc(f_pc), .f_class(f_class),
    .f_mode(f_mode), .f_len(f_len), .f_opnd(f_opnd), .fifo_level(fifo_level),
    .p_valid(p_valid), .p_redir(p_redir), .p_addr(p_addr), .p_tag(p_tag),
    .x_valid(x_valid), .x_pc(x_pc), .x_taken(x_taken), .x_next(x_next), .x_tag(x_tag),
    .r_valid(r_valid), .r_cost(r_cost), .r_flush(r_flush), .r_addr(r_addr)
  );

  typedef struct {
    logic [3:0]    cost;
    bit            flush;
    logic [AW-1:0] addr;
    string         rq;
  } exp_t;

  exp_t q[$];
  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  task automatic chk(input bit ok, input string rq, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  // Scoreboard monitor for resolution results
  always @(negedge clk) begin
    if (rst_n && r_valid) begin
      if (q.size() == 0) begin
        chk(1'b0, "unexpected result", {28'd0, r_cost}, '0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(r_cost == e.cost, {e.rq, " cost"}, {28'd0, r_cost}, {28'd0, e.cost});
        chk(r_flush == e.flush, {e.rq, " flush"}, {31'd0, r_flush}, {31'd0, e.flush});
        if (e.flush) chk(r_addr == e.addr, {e.rq, " addr"}, r_addr, e.addr);
      end
    end
  end

  task automatic fetch(input logic [2:0] cls, input logic [2:0] md, input logic [AW-1:0] pc,
                       input logic [AW-1:0] opnd, input logic [3:0] len, input logic [LW-1:0] lvl,
                       input bit exp_redir, input logic [AW-1:0] exp_addr, input string rq,
                       output logic [TAGW-1:0] tg);
    f_valid = 1'b1; f_class = cls; f_mode = md; f_pc = pc; f_opnd = opnd;
    f_len = len; fifo_level = lvl;
    @(negedge clk);
    f_valid = 1'b0;
    chk(p_valid == 1'b1, {rq, " valid"}, {31'd0, p_valid}, 1);
    chk(p_redir == exp_redir, {rq, " redirect"}, {31'd0, p_redir}, {31'd0, exp_redir});
    if (exp_redir) chk(p_addr == exp_addr, {rq, " target"}, p_addr, exp_addr);
    tg = p_tag;
  endtask

  task automatic resolve(input logic [TAGW-1:0] tg, input logic [AW-1:0] pc, input bit tk,
                         input logic [AW-1:0] nx, input logic [3:0] ec, input bit ef, input string rq);
    exp_t e;
    e.cost = ec; e.flush = ef; e.addr = nx; e.rq = rq;
    q.push_back(e);
    x_valid = 1'b1; x_tag = tg; x_pc = pc; x_taken = tk; x_next = nx;
    @(negedge clk);
    x_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", '0, '0);
    finish_run();
  end

  initial begin
    logic [TAGW-1:0] t, tb;
    rst_n = 1'b0; f_valid = 0; x_valid = 0; x_taken = 0;
    f_pc = '0; f_opnd = '0; f_class = '0; f_mode = '0; f_len = '0; fifo_level = '0;
    x_pc = '0; x_next = '0; x_tag = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(p_valid == 1'b0, "R13 p_valid", {31'd0, p_valid}, 0);
    chk(r_valid == 1'b0, "R13 r_valid", {31'd0, r_valid}, 0);

    // R1 R3: accelerated branches, cost from FIFO level
    fetch(BC_BRA, AM_IND, 32'h100, 32'h40, 2, 0, 1, 32'h140, "R1 bra", t);
    resolve(t, 32'h100, 1, 32'h140, 4'd3, 0, "R3 level0");
    fetch(BC_JMP, AM_ABS, 32'h200, 32'h8000, 4, 1, 1, 32'h8000, "R1 jmp abs", t);
    resolve(t, 32'h200, 1, 32'h8000, 4'd2, 0, "R3 level1");
    fetch(BC_JMP, AM_DPC, 32'h200, 32'h30, 4, 5, 1, 32'h230, "R1 jmp pcrel", t);
    resolve(t, 32'h200, 1, 32'h230, 4'd1, 0, "R3 level5");

    // R2: indirect jump, no early redirect
    fetch(BC_JMP, AM_IND, 32'h300, 32'h0, 2, 0, 0, '0, "R2 jmp ind", t);
    resolve(t, 32'h300, 1, 32'h9000, 4'd5, 1, "R2 fixed");
    fetch(BC_CALL, AM_XPC, 32'h310, 32'h0, 4, 0, 0, '0, "R2 call idx", t);
    resolve(t, 32'h310, 1, 32'h9100, 4'd5, 1, "R2 call fixed");
    fetch(BC_RET, AM_IND, 32'h9104, 32'h0, 2, 0, 1, 32'h314, "R4 ret after slow call", t);
    resolve(t, 32'h9104, 1, 32'h314, 4'd2, 0, "R5 ok slow call");

    // R6: empty stack
    fetch(BC_RET, AM_IND, 32'h320, 32'h0, 2, 0, 0, '0, "R6 ret empty", t);
    resolve(t, 32'h320, 1, 32'h1234, 4'd8, 1, "R6 unpredicted");

    // R4 R5: call/return pairs
    fetch(BC_CALL, AM_ABS, 32'h400, 32'h5000, 6, 2, 1, 32'h5000, "R1 call abs", t);
    resolve(t, 32'h400, 1, 32'h5000, 4'd1, 0, "R3 call level2");
    fetch(BC_RET, AM_IND, 32'h5010, 32'h0, 2, 0, 1, 32'h406, "R4 ret", t);
    resolve(t, 32'h5010, 1, 32'h406, 4'd2, 0, "R5 correct");
    fetch(BC_CALL, AM_DPC, 32'h420, 32'h100, 2, 2, 1, 32'h520, "R1 call pcrel", t);
    fetch(BC_RET, AM_IND, 32'h530, 32'h0, 2, 0, 1, 32'h422, "R4 ret2", t);
    resolve(t, 32'h530, 1, 32'h777, 4'd9, 1, "R5 wrong");

    // R7: overflow wraps over the oldest entry
    for (int i = 0; i < DEP + 1; i++)
      fetch(BC_CALL, AM_ABS, 32'h1000 + i * 32'h100, 32'h9000, 2, 0, 1, 32'h9000, "R7 call", t);
    for (int i = 0; i < DEP; i++)
      fetch(BC_RET, AM_IND, 32'h9000, 32'h0, 2, 0, 1, 32'h1402 - i * 32'h100, "R7 ret", t);
    fetch(BC_RET, AM_IND, 32'h9000, 32'h0, 2, 0, 0, '0, "R7 oldest lost", t);

    // R8: reset counter predicts not taken
    fetch(BC_BCC, AM_DPC, 32'h2002, 32'h20, 2, 0, 0, '0, "R8 bcc nt", t);
    resolve(t, 32'h2002, 0, 32'h2004, 4'd1, 0, "R8 nt correct");
    // R11: mispredict
    fetch(BC_BCC, AM_DPC, 32'h2004, 32'h3c, 2, 0, 0, '0, "R11 bcc", t);
    resolve(t, 32'h2004, 1, 32'h2040, 4'd8, 1, "R11 mispredict");
    // R9: cache hit
    fetch(BC_BCC, AM_DPC, 32'h2004, 32'h3c, 2, 0, 1, 32'h2040, "R9 hit", t);
    resolve(t, 32'h2004, 1, 32'h2040, 4'd0, 0, "R9 zero cost");
    // R10: alias index, different tag
    fetch(BC_BCC, AM_DPC, 32'h3004, 32'h10, 2, 0, 1, 32'h3014, "R10 table taken", t);
    resolve(t, 32'h3004, 1, 32'h3014, 4'd1, 0, "R10 cost");
    // R11: counter trained down by not-taken mispredict
    fetch(BC_BCC, AM_DPC, 32'h3004, 32'h10, 2, 0, 1, 32'h3014, "R11 hit again", t);
    resolve(t, 32'h3004, 0, 32'h3006, 4'd8, 1, "R11 taken mispredict");

    // R12: rollback and same-cycle fetch drop
    fetch(BC_CALL, AM_ABS, 32'h600, 32'h700, 2, 0, 1, 32'h700, "R12 call", t);
    fetch(BC_BCC, AM_DPC, 32'h2002, 32'h20, 2, 0, 0, '0, "R12 bcc", tb);
    fetch(BC_CALL, AM_ABS, 32'h700, 32'h900, 2, 0, 1, 32'h900, "R12 wrong-path call", t);
    begin
      exp_t e;
      e.cost = 4'd8; e.flush = 1; e.addr = 32'h2100; e.rq = "R12 flush";
      q.push_back(e);
    end
    x_valid = 1; x_tag = tb; x_pc = 32'h2002; x_taken = 1; x_next = 32'h2100;
    f_valid = 1; f_class = BC_CALL; f_mode = AM_ABS; f_pc = 32'h800; f_opnd = 32'hA00; f_len = 2;
    @(negedge clk);
    x_valid = 0; f_valid = 0;
    chk(p_valid == 1'b0, "R12 fetch dropped", {31'd0, p_valid}, 0);
    fetch(BC_RET, AM_IND, 32'h2100, 32'h0, 2, 0, 1, 32'h602, "R12 rolled back", t);

    repeat (3) @(negedge clk);
    chk(q.size() == 0, "scoreboard drained", q.size(), 0);
    finish_run();
  end

endmodule